// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Enable Divider

This block derives a slow timing strobe from a fast master clock. A 4-bit select input chooses a division factor that is a power of two, from 1 up to 256. The block produces a single-cycle enable pulse once per divided period. Downstream logic runs on the master clock and qualifies its registers with that pulse. The period counter always runs on the undivided master clock.

The select may change at any time while the block runs. The block captures a new select value only at the end of the period in progress. Every interval between pulses is therefore exactly one whole old period or one whole new period. No shortened interval is ever emitted, and the time the change takes to settle has a fixed upper bound. Reserved select codes fall back to the slowest ratio.

Top module: `pow2_clk_div`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the active factor is 1 (code 0), so `en_o` is high.
- R2: With select code k held at 0 to 8, `en_o` is high for exactly one master cycle in every 2^k master cycles.
- R3: Select codes 9 to 15 give a division factor of 256, the same as code 8.
- R4: While the active factor is 1, `en_o` is high in every cycle.
- R5: The block samples `sel_i` only on the clock edge that follows a cycle in which `en_o` is high. The period in progress always completes at its old length.
- R6: No interval between two consecutive `en_o` pulses is shorter than the smaller of the old and the new period. Each interval equals one of those two periods.
- R7: Take a select change of period T1 to period T2, held afterwards. The first pulse that ends a full new-length period comes at least T2 and at most T1+T2 master cycles after the change.
- R8: A select value that is present only between two period boundaries has no effect on the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Undivided master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Division select code; factor 2^code, and codes above 8 act as 256 |
| en_o | output | 1 | Single-cycle enable pulse, once per divided period |

## Verification
The assertions assume that `sel_i` is synchronous to `clk_i` and is stable around each rising edge. They make no assumption about when the select changes relative to period boundaries. The stimulus drives `sel_i` a quarter period after each rising edge. It changes the select at arbitrary points inside a period, including short excursions that end before the next boundary.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned MAX_LOG = 8;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);
  localparam int unsigned CNT_W   = MAX_LOG;
endpackage

// File: rtl/pow2_sel_decode.sv
module pow2_sel_decode #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MAX_LOG = 8,
  parameter int unsigned LOG_W   = $clog2(MAX_LOG + 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LOG_W-1:0] log_o
);
  // reserved codes saturate to the slowest ratio
  always_comb begin
    if (32'(sel_i) > MAX_LOG) log_o = LOG_W'(MAX_LOG);
    else                      log_o = LOG_W'(sel_i);
  end
endmodule

// File: rtl/pow2_period_cnt.sv
module pow2_period_cnt #(
  parameter int unsigned MAX_LOG = 8,
  parameter int unsigned LOG_W   = $clog2(MAX_LOG + 1),
  parameter int unsigned CNT_W   = MAX_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG_W-1:0] log_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // last count of the period = 2^log - 1, built bit by bit
  for (genvar b = 0; b < CNT_W; b++) begin : g_last
    assign last[b] = (32'(log_i) > b);
  end

  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
#(
  parameter int unsigned RST_LOG = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o
);
  logic [LOG_W-1:0] dec_log;
  logic [LOG_W-1:0] act_log_q;
  logic             tick;

  pow2_sel_decode #(
    .SEL_W  (SEL_W),
    .MAX_LOG(MAX_LOG),
    .LOG_W  (LOG_W)
  ) i_decode (
    .sel_i(sel_i),
    .log_o(dec_log)
  );

  // ratio captured only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_log_q <= LOG_W'(RST_LOG);
    else if (tick) act_log_q <= dec_log;
  end

  pow2_period_cnt #(
    .MAX_LOG(MAX_LOG),
    .LOG_W  (LOG_W),
    .CNT_W  (CNT_W)
  ) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .log_i (act_log_q),
    .tick_o(tick)
  );

  assign en_o = tick;

  assert_ratio_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(act_log_q));

  assert_ratio_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(act_log_q) <= MAX_LOG);

  assert_div1_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_log_q == '0) |-> en_o);

  assert_no_short_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && dec_log != '0) |=> !en_o);
endmodule

// File: tb/test_pow2_clk_div.sv
module test_pow2_clk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_i = 4'd0;
  logic       en_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];
  int m_len = 1;
  int m_rem = 1;
  bit done = 0;

  pow2_clk_div i_pow2_clk_div (.clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .en_o(en_o));

  always #10ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int len_of(input logic [3:0] s);
    return (s > 4'd8) ? 256 : (1 << s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // model pushes predicted pulse cycles, monitor pops them as pulses appear
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (m_rem == 1) exp_q.push_back(cyc);
      if (en_o === 1'b1) begin
        if (exp_q.size() == 0) check("R2 unexpected pulse", cyc, -1);
        else check("R2 pulse time", cyc, exp_q.pop_front());
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        check("R2 missing pulse", -1, exp_q.pop_front());
      end
      if (m_rem == 1) begin
        m_len = len_of(sel_i);
        m_rem = m_len;
      end else m_rem--;
    end
  end

  task automatic next_pulse(output int c);
    do @(negedge clk_i); while (en_o !== 1'b1);
    c = cyc;
  endtask

  task automatic set_sel(input logic [3:0] s);
    @(posedge clk_i);
    #5ns sel_i = s;
  endtask

  task automatic gap_for(input logic [3:0] s, input string req);
    int p0, p1, p2;
    set_sel(s);
    next_pulse(p0);
    next_pulse(p1);
    next_pulse(p2);
    check(req, p2 - p1, len_of(s));
  endtask

  initial begin
    int p0, p1, p2, c0;
    @(negedge clk_i);
    check("R1 en during reset", en_o, 1);
    @(posedge clk_i);
    #5ns rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 en after release", en_o, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check("R4 divide-by-1 steady", en_o, 1);
    end
    for (int k = 1; k <= 8; k++) gap_for(4'(k), "R2 period");
    gap_for(4'd9,  "R3 reserved code 9");
    gap_for(4'd12, "R3 reserved code 12");
    gap_for(4'd15, "R3 reserved code 15");
    // mid-period change 32 -> 4
    gap_for(4'd5, "R2 period 32");
    next_pulse(p0);
    repeat (10) @(posedge clk_i);
    #5ns sel_i = 4'd2;
    c0 = cyc;
    next_pulse(p1);
    check("R5 old period completes", p1 - p0, 32);
    next_pulse(p2);
    check("R6 new period exact", p2 - p1, 4);
    check_range("R7 changeover latency", p2 - c0, 4, 36);
    // short excursion inside a period is ignored
    gap_for(4'd6, "R2 period 64");
    next_pulse(p0);
    repeat (5) @(posedge clk_i);
    #5ns sel_i = 4'd1;
    repeat (5) @(posedge clk_i);
    #5ns sel_i = 4'd6;
    next_pulse(p1);
    next_pulse(p2);
    check("R8 excursion ignored", p1 - p0, 64);
    check("R8 excursion ignored next", p2 - p1, 64);
    // slow to fast back to divide-by-1
    set_sel(4'd0);
    next_pulse(p0);
    repeat (2) @(negedge clk_i);
    check("R4 return to divide-by-1", en_o, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule